// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block is a DMA front end for a configuration item store. Software places a 16-byte descriptor in memory and writes the descriptor's 64-bit bus address to a doorbell. The engine then reads the descriptor, optionally selects a new item, and either copies item bytes into memory or skips over them. It finishes by writing a 32-bit status word back into the descriptor.

The descriptor is big-endian. Bytes 0..7 hold the target address, bytes 8..11 the length and bytes 12..15 the control word. The item store is outside the block. It holds the current item key and byte offset, and it exposes the byte at the current offset together with a flag that says whether that byte exists. The memory side is a byte-wide master with a request/grant handshake.

A read of the doorbell region returns a fixed 8-byte ASCII signature, "CFGDMA!!". Software can use it to probe for the engine.

Top module: `cfgdma_engine`

## Requirements
- R1: Doorbell writes are accepted only when the engine is idle, and only in three forms. A write with size 4 at offset 0 loads the high address half from wdata[31:0] and clears the low half. A write with size 4 at offset 4 ORs wdata[31:0] into the low half and starts a transfer. A write with size 8 at offset 0 loads the full address and starts a transfer. Every other write is ignored.
- R2: The stored descriptor address returns to zero in the cycle a transfer starts. A later write of only the low half therefore uses a high half of zero.
- R3: The engine fetches 16 descriptor bytes from base+0 to base+15, in increasing address order. It reads them big-endian as address (bytes 0..7), length (bytes 8..11) and control (bytes 12..15). Only the control field is ever written back.
- R4: The control word uses these bits: bit 0 is error, bit 1 is read, bit 2 is skip and bit 3 is select. When select is set, control[31:16] is selected as the new item key, which resets the item offset to zero before any data moves. The error bit is ignored on input.
- R5: Read takes priority over skip. If neither bit is set, no data moves, the item offset is unchanged and the status written back is 0.
- R6: A read copies item bytes, in offset order, to consecutive target addresses. Each byte advances the item offset by one. Without select, a transfer continues from the offset left by the previous one.
- R7: On a read, once the item is invalid, empty or exhausted, the remaining target bytes are written with 0x00.
- R8: A skip advances the item offset without writing memory. Any length beyond the item's end is consumed with no effect.
- R9: On completion, the engine writes the status as a big-endian 32-bit value to base+12..base+15. The status is 0x00000000 on success and 0x00000001 after a memory error. A memory error during data movement ends the transfer at that byte.
- R10: If a descriptor fetch beat returns an error, no data moves and the status 0x00000001 is written to base+12..15.
- R11: A doorbell read of size 1, 2, 4 or 8 at offset o returns the signature bytes o..o+size-1, taken big-endian. The signature is 0x43464744_4D412121. An access that runs past byte 7 returns 0.
- R12: The busy output is high from the accepted start until the last status byte is granted. While busy is low, the engine issues no memory requests and no item-store strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Doorbell write strobe |
| reg_off | input | 3 | Doorbell byte offset |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Doorbell write data |
| reg_rdata | output | 64 | Signature read data (combinational) |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request, held until grant |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_gnt | input | 1 | Grant; completes the beat |
| mem_rdata | input | 8 | Read byte, valid with grant |
| mem_err | input | 1 | Beat error, valid with grant |
| st_sel | output | 1 | Select strobe for the item store |
| st_key | output | 16 | Key to select |
| st_rd | output | 1 | Consume the current item byte |
| st_avail | input | 1 | The current offset holds a byte |
| st_rdata | input | 8 | Byte at the current offset |

## Verification
The assertions assume that grant, read data and error come from a memory that answers only a pending request. They also assume that the item store changes its available flag and data byte only on a select or consume strobe.

The bench's memory model raises a grant only while a request is pending, and it decides that grant away from the clock edge. Its item store moves its offset only on the engine's strobes. Descriptor placement, the bad-address window and item lengths are chosen so that each chunk, zero-fill, skip and error boundary falls on a known byte.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_FETCH, SQ_DECODE, SQ_MOVE, SQ_REPORT
  } seq_state_t;

  localparam int CTL_ERR_BIT  = 0;
  localparam int CTL_READ_BIT = 1;
  localparam int CTL_SKIP_BIT = 2;
  localparam int CTL_SEL_BIT  = 3;

  localparam int DESC_BYTES    = 16;
  localparam int STATUS_OFFSET = 12;
  localparam int STATUS_BYTES  = 4;
endpackage

// File: rtl/cfgdma_doorbell.sv
module cfgdma_doorbell #(
  parameter int          ADDR_W    = 64,
  parameter logic [63:0] SIGNATURE = 64'h4346_4744_4D41_2121
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_off,
  input  logic [3:0]        reg_size,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              busy,
  output logic              kick,
  output logic [ADDR_W-1:0] kick_addr
);
  localparam int HALF_W = ADDR_W / 2;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic              wr_hi, wr_lo, wr_full;

  always_comb begin
    wr_hi   = reg_wr && !busy && (reg_size == 4'd4) && (reg_off == 3'd0);
    wr_lo   = reg_wr && !busy && (reg_size == 4'd4) && (reg_off == 3'd4);
    wr_full = reg_wr && !busy && (reg_size == 4'd8) && (reg_off == 3'd0);
    kick    = wr_lo || wr_full;
    kick_addr = wr_full ? reg_wdata
                        : (addr_q | {{HALF_W{1'b0}}, reg_wdata[HALF_W-1:0]});
    addr_en = wr_hi || kick;
    addr_d  = wr_hi ? {reg_wdata[HALF_W-1:0], {HALF_W{1'b0}}} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  logic [3:0]  end_pos;
  logic        size_ok;
  logic [63:0] shifted, mask;

  always_comb begin
    end_pos = {1'b0, reg_off} + reg_size;
    size_ok = (reg_size == 4'd1) || (reg_size == 4'd2) ||
              (reg_size == 4'd4) || (reg_size == 4'd8);
    shifted = SIGNATURE >> {4'd8 - end_pos, 3'b000};
    mask    = (reg_size == 4'd8) ? {64{1'b1}}
                                 : ((64'd1 << {reg_size, 3'b000}) - 64'd1);
    reg_rdata = (size_ok && end_pos <= 4'd8) ? (shifted & mask) : 64'd0;
  end
endmodule

// File: rtl/cfgdma_desc_buf.sv
module cfgdma_desc_buf #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int CTL_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [7:0]        shift_byte,
  output logic [ADDR_W-1:0] d_addr,
  output logic [LEN_W-1:0]  d_len,
  output logic [CTL_W-1:0]  d_ctl
);
  localparam int TOTAL_W = ADDR_W + LEN_W + CTL_W;

  logic [TOTAL_W-1:0] desc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        desc_q <= '0;
    else if (shift_en) desc_q <= {desc_q[TOTAL_W-9:0], shift_byte};
  end

  assign d_addr = desc_q[TOTAL_W-1 -: ADDR_W];
  assign d_len  = desc_q[CTL_W +: LEN_W];
  assign d_ctl  = desc_q[0 +: CTL_W];
endmodule

// File: rtl/cfgdma_seq.sv
module cfgdma_seq
  import cfgdma_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int CTL_W  = 32,
  parameter int KEY_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic [ADDR_W-1:0] kick_addr,
  output logic              busy,
  output seq_state_t        state_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_err,
  output logic              st_sel,
  output logic [KEY_W-1:0]  st_key,
  output logic              st_rd,
  input  logic              st_avail,
  input  logic [7:0]        st_rdata,
  output logic              shift_en,
  output logic [7:0]        shift_byte,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [LEN_W-1:0]  d_len,
  input  logic [CTL_W-1:0]  d_ctl
);
  localparam int CNT_W = $clog2(DESC_BYTES);

  seq_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] base_q, base_d, cur_q, cur_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              rd_mode_q, rd_mode_d;
  logic              err_q, err_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    base_d    = base_q;
    cur_d     = cur_q;
    rem_d     = rem_q;
    rd_mode_d = rd_mode_q;
    err_d     = err_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = 8'h00;
    st_sel    = 1'b0;
    st_key    = '0;
    st_rd     = 1'b0;
    shift_en  = 1'b0;
    shift_byte = mem_rdata;

    case (state_q)
      SQ_IDLE: begin
        if (kick) begin
          base_d  = kick_addr;
          cnt_d   = '0;
          err_d   = 1'b0;
          state_d = SQ_FETCH;
        end
      end
      SQ_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = base_q + ADDR_W'(cnt_q);
        if (mem_gnt) begin
          if (mem_err) begin
            err_d   = 1'b1;
            cnt_d   = '0;
            state_d = SQ_REPORT;
          end else begin
            shift_en = 1'b1;
            cnt_d    = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DESC_BYTES - 1)) begin
              cnt_d   = '0;
              state_d = SQ_DECODE;
            end
          end
        end
      end
      SQ_DECODE: begin
        st_sel = d_ctl[CTL_SEL_BIT];
        st_key = d_ctl[CTL_W-1 -: KEY_W];
        cur_d  = d_addr;
        if (d_ctl[CTL_READ_BIT]) begin
          rd_mode_d = 1'b1;
          rem_d     = d_len;
        end else if (d_ctl[CTL_SKIP_BIT]) begin
          rd_mode_d = 1'b0;
          rem_d     = d_len;
        end else begin
          rd_mode_d = 1'b0;
          rem_d     = '0;
        end
        state_d = SQ_MOVE;
      end
      SQ_MOVE: begin
        if (rem_q == '0) begin
          cnt_d   = '0;
          state_d = SQ_REPORT;
        end else if (rd_mode_q) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = cur_q;
          mem_wdata = st_avail ? st_rdata : 8'h00;
          if (mem_gnt) begin
            st_rd = st_avail;
            cur_d = cur_q + 1'b1;
            rem_d = rem_q - 1'b1;
            if (mem_err) begin
              err_d   = 1'b1;
              cnt_d   = '0;
              state_d = SQ_REPORT;
            end
          end
        end else if (st_avail) begin
          st_rd = 1'b1;
          cur_d = cur_q + 1'b1;
          rem_d = rem_q - 1'b1;
        end else begin
          cur_d = cur_q + ADDR_W'(rem_q);
          rem_d = '0;
        end
      end
      SQ_REPORT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = base_q + ADDR_W'(STATUS_OFFSET) + ADDR_W'(cnt_q);
        mem_wdata = (cnt_q == CNT_W'(STATUS_BYTES - 1)) ? {7'd0, err_q} : 8'h00;
        if (mem_gnt) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(STATUS_BYTES - 1)) state_d = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      cnt_q     <= '0;
      base_q    <= '0;
      cur_q     <= '0;
      rem_q     <= '0;
      rd_mode_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      base_q    <= base_d;
      cur_q     <= cur_d;
      rem_q     <= rem_d;
      rd_mode_q <= rd_mode_d;
      err_q     <= err_d;
    end
  end

  assign busy    = (state_q != SQ_IDLE);
  assign state_o = state_q;
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
  import cfgdma_pkg::*;
#(
  parameter int          ADDR_W    = 64,
  parameter int          LEN_W     = 32,
  parameter int          CTL_W     = 32,
  parameter int          KEY_W     = 16,
  parameter logic [63:0] SIGNATURE = 64'h4346_4744_4D41_2121
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_off,
  input  logic [3:0]        reg_size,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_err,
  output logic              st_sel,
  output logic [KEY_W-1:0]  st_key,
  output logic              st_rd,
  input  logic              st_avail,
  input  logic [7:0]        st_rdata
);
  logic              kick;
  logic [ADDR_W-1:0] kick_addr;
  logic              shift_en;
  logic [7:0]        shift_byte;
  logic [ADDR_W-1:0] d_addr;
  logic [LEN_W-1:0]  d_len;
  logic [CTL_W-1:0]  d_ctl;
  seq_state_t        seq_state;

  cfgdma_doorbell #(.ADDR_W(ADDR_W), .SIGNATURE(SIGNATURE)) u_bell (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .kick(kick), .kick_addr(kick_addr)
  );

  cfgdma_desc_buf #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CTL_W(CTL_W)) u_desc (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .shift_byte(shift_byte),
    .d_addr(d_addr), .d_len(d_len), .d_ctl(d_ctl)
  );

  cfgdma_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CTL_W(CTL_W), .KEY_W(KEY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .kick(kick), .kick_addr(kick_addr),
    .busy(busy), .state_o(seq_state),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .st_sel(st_sel), .st_key(st_key), .st_rd(st_rd),
    .st_avail(st_avail), .st_rdata(st_rdata), .shift_en(shift_en),
    .shift_byte(shift_byte), .d_addr(d_addr), .d_len(d_len), .d_ctl(d_ctl)
  );
endmodule

// File: rtl/cfgdma_engine_chk.sv
module cfgdma_engine_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_off,
  input logic [3:0]        reg_size,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_gnt,
  input logic              st_sel,
  input logic              st_rd,
  input logic              st_avail
);
  AST_FULL_KICK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !busy && reg_size == 4'd8 && reg_off == 3'd0) |=> busy); // R1

  AST_LOW_KICK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !busy && reg_size == 4'd4 && reg_off == 3'd4) |=> busy); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !st_rd && !st_sel)); // R12

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata))); // R6

  AST_ITEM_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_sel, st_rd})); // R4

  AST_SELECT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    st_sel |-> !mem_req); // R4

  AST_CONSUME_ONLY_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd |-> st_avail); // R8
endmodule

bind cfgdma_engine cfgdma_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
  .reg_size(reg_size), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
  .st_sel(st_sel), .st_rd(st_rd), .st_avail(st_avail)
);

// File: tb/cfgdma_engine_tb_top.sv
module cfgdma_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_off;
  logic [3:0]  reg_size;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic        busy;
  logic        mem_req, mem_we, mem_gnt, mem_err;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        st_sel, st_rd, st_avail;
  logic [15:0] st_key;
  logic [7:0]  st_rdata;

  always #2 clk = ~clk;

  cfgdma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .st_sel(st_sel), .st_key(st_key), .st_rd(st_rd),
    .st_avail(st_avail), .st_rdata(st_rdata)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // memory model: 1 KiB, bad window [err_lo, err_hi], grants every other cycle
  logic [7:0] mem [0:1023];
  int  err_lo = 32'h300;
  int  err_hi = 32'h37F;
  bit  stall = 0;

  function automatic bit is_bad(input logic [63:0] a);
    return (a >= 64'd1024) || (a >= 64'(err_lo) && a <= 64'(err_hi));
  endfunction

  always @(negedge clk) begin
    mem_gnt   = 1'b0;
    mem_err   = 1'b0;
    mem_rdata = 8'h00;
    if (rst_n && mem_req) begin
      if (!stall) begin
        mem_gnt = 1'b1;
        mem_err = is_bad(mem_addr);
        if (!mem_err) begin
          if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
          else        mem_rdata = mem[mem_addr[9:0]];
        end
      end
      stall = ~stall;
    end
  end

  // item store model: key 0 len 5, key 1 empty, key 2 len 12, key 3 len 3
  logic [15:0] cur_key;
  int          cur_off;

  function automatic int item_len(input logic [15:0] k);
    case (k)
      16'd0: return 5;
      16'd1: return 0;
      16'd2: return 12;
      16'd3: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] item_byte(input logic [15:0] k, input int o);
    return 8'h40 + {k[3:0], 4'h0} + o[7:0];
  endfunction

  assign st_avail = (cur_off < item_len(cur_key));
  assign st_rdata = st_avail ? item_byte(cur_key, cur_off) : 8'h00;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_key <= 16'd0;
      cur_off <= 0;
    end else if (st_sel) begin
      cur_key <= st_key;
      cur_off <= 0;
    end else if (st_rd) begin
      cur_off <= cur_off + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic db_write(input logic [2:0] off, input logic [3:0] sz, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = off; reg_size = sz; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle;
    int n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (busy) chk("R12 timeout waiting for idle", 1, 0);
  endtask

  task automatic run_full(input logic [63:0] a);
    db_write(3'd0, 4'd8, a);
    wait_idle();
  endtask

  task automatic put_desc(input int b, input logic [63:0] tgt, input logic [31:0] len,
                          input logic [31:0] ctl);
    for (int i = 0; i < 8; i++) mem[b + i] = tgt[63 - 8*i -: 8];
    for (int i = 0; i < 4; i++) mem[b + 8 + i] = len[31 - 8*i -: 8];
    for (int i = 0; i < 4; i++) mem[b + 12 + i] = ctl[31 - 8*i -: 8];
  endtask

  function automatic logic [31:0] rd32(input int a);
    return {mem[a], mem[a+1], mem[a+2], mem[a+3]};
  endfunction

  task automatic t_reset;
    chk("R12 busy after reset", busy, 0);
    chk("R12 no request after reset", mem_req, 0);
  endtask

  task automatic t_signature;
    @(negedge clk);
    reg_off = 3'd0; reg_size = 4'd8; #1;
    chk("R11 sig 8@0", reg_rdata, 64'h4346_4744_4D41_2121);
    reg_off = 3'd4; reg_size = 4'd4; #1;
    chk("R11 sig 4@4", reg_rdata, 64'h4D41_2121);
    reg_off = 3'd2; reg_size = 4'd2; #1;
    chk("R11 sig 2@2", reg_rdata, 64'h4744);
    reg_off = 3'd7; reg_size = 4'd1; #1;
    chk("R11 sig 1@7", reg_rdata, 64'h21);
    reg_off = 3'd6; reg_size = 4'd4; #1;
    chk("R11 sig past end", reg_rdata, 64'h0);
  endtask

  task automatic t_read_basic;
    put_desc(32'h000, 64'h200, 32'd5, 32'h0002_000A);
    db_write(3'd0, 4'd4, 64'h0);
    db_write(3'd4, 4'd4, 64'h000);
    wait_idle();
    for (int i = 0; i < 5; i++) chk("R6 read copy", mem[32'h200 + i], 8'h60 + 8'(i));
    chk("R3 length bound", mem[32'h205], 8'hEE);
    chk("R9 success status", rd32(32'h00C), 32'h0);
    chk("R3 length field untouched", rd32(32'h008), 32'd5);
    chk("R4 select of key 2", mem[32'h200], 8'h60);
  endtask

  task automatic t_continue;
    put_desc(32'h020, 64'h210, 32'd3, 32'h0000_0002);
    run_full(64'h020);
    for (int i = 0; i < 3; i++) chk("R6 continue offset", mem[32'h210 + i], 8'h65 + 8'(i));
  endtask

  task automatic t_zero_fill;
    put_desc(32'h040, 64'h220, 32'd6, 32'h0003_000A);
    run_full(64'h040);
    for (int i = 0; i < 3; i++) chk("R7 data before end", mem[32'h220 + i], 8'h70 + 8'(i));
    for (int i = 3; i < 6; i++) chk("R7 zero fill", mem[32'h220 + i], 8'h00);
    chk("R7 fill bound", mem[32'h226], 8'hEE);
  endtask

  task automatic t_skip;
    put_desc(32'h060, 64'h230, 32'd4, 32'h0002_000C);
    run_full(64'h060);
    for (int i = 0; i < 4; i++) chk("R8 skip writes nothing", mem[32'h230 + i], 8'hEE);
    chk("R9 skip status", rd32(32'h06C), 32'h0);
    put_desc(32'h080, 64'h240, 32'd2, 32'h0000_0002);
    run_full(64'h080);
    chk("R8 offset after skip", mem[32'h240], 8'h64);
    chk("R8 offset after skip +1", mem[32'h241], 8'h65);
  endtask

  task automatic t_priority;
    put_desc(32'h0A0, 64'h250, 32'd1, 32'h0000_000E);
    run_full(64'h0A0);
    chk("R5 read beats skip", mem[32'h250], 8'h40);
    put_desc(32'h0C0, 64'h260, 32'd4, 32'h0000_0001);
    run_full(64'h0C0);
    chk("R5 neither bit no data", mem[32'h260], 8'hEE);
    chk("R5 neither bit status 0", rd32(32'h0CC), 32'h0);
    put_desc(32'h0E0, 64'h270, 32'd1, 32'h0000_0002);
    run_full(64'h0E0);
    chk("R5 offset unchanged", mem[32'h270], 8'h41);
  endtask

  task automatic t_skip_end;
    put_desc(32'h100, 64'h280, 32'd10, 32'h0003_000C);
    run_full(64'h100);
    chk("R8 skip past end status", rd32(32'h10C), 32'h0);
    chk("R8 skip past end no write", mem[32'h282], 8'hEE);
    put_desc(32'h120, 64'h281, 32'd1, 32'h0000_0002);
    run_full(64'h120);
    chk("R8 exhausted after skip", mem[32'h281], 8'h00);
  endtask

  task automatic t_invalid_key;
    put_desc(32'h140, 64'h290, 32'd2, 32'h0009_000A);
    run_full(64'h140);
    chk("R7 invalid key zero 0", mem[32'h290], 8'h00);
    chk("R7 invalid key zero 1", mem[32'h291], 8'h00);
    chk("R7 invalid key bound", mem[32'h292], 8'hEE);
  endtask

  task automatic t_mem_error;
    put_desc(32'h160, 64'h2FE, 32'd4, 32'h0000_000A);
    run_full(64'h160);
    chk("R9 byte before error", mem[32'h2FE], 8'h40);
    chk("R9 byte before error +1", mem[32'h2FF], 8'h41);
    chk("R9 error status", rd32(32'h16C), 32'h1);
  endtask

  task automatic t_fetch_error;
    run_full(64'h378);
    chk("R10 fetch error status", rd32(32'h384), 32'h1);
  endtask

  task automatic t_busy_block;
    put_desc(32'h180, 64'h2A0, 32'd2, 32'h0002_000A);
    put_desc(32'h1A0, 64'h2B0, 32'd2, 32'h0002_000A);
    db_write(3'd0, 4'd8, 64'h180);
    chk("R12 busy after start", busy, 1);
    db_write(3'd0, 4'd8, 64'h1A0);
    wait_idle();
    chk("R12 first transfer done", mem[32'h2A0], 8'h60);
    chk("R12 write while busy ignored", mem[32'h2B0], 8'hEE);
    @(negedge clk);
    chk("R12 idle after single transfer", busy, 0);
  endtask

  task automatic t_ignored_and_clear;
    db_write(3'd0, 4'd2, 64'h10);
    chk("R1 size-2 write ignored", busy, 0);
    db_write(3'd2, 4'd4, 64'h10);
    chk("R1 misaligned write ignored", busy, 0);
    put_desc(32'h1C0, 64'h2C0, 32'd1, 32'h0000_000A);
    put_desc(32'h1D0, 64'h2D0, 32'd1, 32'h0000_000A);
    run_full(64'h1D0);
    chk("R1 full-address transfer", mem[32'h2D0], 8'h40);
    mem[32'h2D0] = 8'hEE;
    db_write(3'd4, 4'd4, 64'h1C0);
    wait_idle();
    chk("R2 address cleared before low write", mem[32'h2C0], 8'h40);
    chk("R2 stale address not used", mem[32'h2D0], 8'hEE);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'hEE;
    rst_n = 1'b0; reg_wr = 1'b0; reg_off = 3'd0; reg_size = 4'd0; reg_wdata = 64'd0;
    mem_gnt = 1'b0; mem_err = 1'b0; mem_rdata = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_signature();
    t_read_basic();
    t_continue();
    t_zero_fill();
    t_skip();
    t_priority();
    t_skip_end();
    t_invalid_key();
    t_mem_error();
    t_fetch_error();
    t_busy_block();
    t_ignored_and_clear();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule